// File: doc/BRIEF.md
# Memory-Window Bus Bridge Decoder

This block sits between the bus of an 8-bit microprocessor and a graphics memory. It decides how each processor memory cycle is handled. A cycle that falls inside a configurable bank window and below the implemented memory size becomes a one-clock read or write request to the memory. The request carries the low 20 address bits. Read data returns to the processor once the memory flags it ready.

Some reads land inside the bank but above the implemented memory. These are answered at once, with no memory request. The top 16 addresses of the window return bytes from an identification table. Every other address in that gap returns the filler value 0xFF. Writes to the gap are dropped.

Whenever the block drives read data, it turns the external bus transceiver toward the processor and enables it. When the read strobe goes away, it releases the transceiver.

Top module: `mem_window_bridge`

## Requirements
- R1: During and after a synchronous active-low reset, with no cycle applied: `mem_rd_req` = 0, `mem_wr_req` = 0, `cpu_rdata_en` = 0, `xcvr_dir_out` = 0 and `xcvr_oe_n` = 1.
- R2: An access is in the bank only when `addr[21:19]` equals `BANK_SEL` (default 3'b010). A read or write outside the bank issues no request, and no read data is driven.
- R3: A read request is issued for a rising `rd_pulse` only when the access is in the bank and `addr[18:0]` < `MEM_SIZE` (default 0x40000). The request has these properties:
  - `mem_rd_req` is high for exactly the one clock after the edge that sampled `rd_pulse`.
  - `mem_addr` carries `addr[19:0]`.
- R4: A write request follows the same rules and timing, with `wr_pulse` and `mem_wr_req`. A write in the bank with an offset at or above `MEM_SIZE` issues no request.
- R5: For an in-range read, `cpu_rdata` takes `mem_rdata` at the first clock edge where `rd_level` and `mem_rdy` are both high. Until that edge, `cpu_rdata_en` stays 0.
- R6: For a read in the bank with `addr[18:4]` all ones and an offset at or above `MEM_SIZE`, the following hold:
  - `cpu_rdata` is ID table entry `addr[3:0]`.
  - The data is valid at the first edge that samples `rd_level` high, without waiting for `mem_rdy`.
  - No memory request is issued.
  - With the default table, entry k is 0x40+k.
- R7: Any other in-bank read with an offset at or above `MEM_SIZE` returns 0xFF at the first edge that samples `rd_level` high, with no request.
- R8: Whenever read data is driven, the following outputs hold: `cpu_rdata_en` = 1, `xcvr_dir_out` = 1 (toward the processor) and `xcvr_oe_n` = 0.
- R9: At the first edge that samples `rd_level` low, the outputs return to `cpu_rdata_en` = 0, `xcvr_dir_out` = 0 and `xcvr_oe_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 22 | Registered processor address |
| rd_level | input | 1 | Memory read cycle active (level) |
| wr_level | input | 1 | Memory write cycle active (level) |
| rd_pulse | input | 1 | One-clock strobe at start of a read |
| wr_pulse | input | 1 | One-clock strobe at start of a write |
| mem_rdata | input | 8 | Read data from graphics memory |
| mem_rdy | input | 1 | Memory read data valid |
| mem_rd_req | output | 1 | One-clock memory read request |
| mem_wr_req | output | 1 | One-clock memory write request |
| mem_addr | output | 20 | Memory request address |
| cpu_rdata | output | 8 | Data returned to the processor |
| cpu_rdata_en | output | 1 | Read data is being driven |
| xcvr_dir_out | output | 1 | Transceiver direction, 1 = toward processor |
| xcvr_oe_n | output | 1 | Transceiver output enable, active low |

## Verification
The assertions check the following on every cycle:
- A memory request only ever follows a strobe at an in-bank, in-range address.
- Read and write requests never coincide.
- The transceiver controls agree with the read-data enable.
- The outputs are released after the read strobe falls.

Only the bench scenarios show that the returned bytes are right. These cover memory data, each ID table slot and the 0xFF filler. The bench also shows the exact cycle in which data appears: immediate for the gap above memory, and gated by a delayed ready for memory. It further shows that writes outside the window or above the memory size leave no trace.

// File: rtl/bridge_pkg.sv
// bridge_pkg: shared source-selection type for the memory-window bridge.
package bridge_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_ID   = 2'd2,
        SRC_FILL = 2'd3
    } rd_src_e;
endpackage

// File: rtl/bridge_window_decode.sv
// bridge_window_decode: classifies an address against the bank window.
// Assumes the bank field is the top BANK_W bits of the address. The ID
// slots are the 16 highest offsets of the window.
module bridge_window_decode #(
    parameter int unsigned ADDR_W   = 22,
    parameter int unsigned BANK_W   = 3,
    parameter logic [BANK_W-1:0] BANK_SEL = 3'b010,
    parameter int unsigned MEM_SIZE = 32'h40000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_bank,
    output logic              in_range,
    output logic              in_id
);
    localparam int unsigned OFF_W = ADDR_W - BANK_W;

    logic [OFF_W-1:0] offset;

    // Split the address into bank field and offset and compare each.
    always_comb begin
        offset   = addr[OFF_W-1:0];
        in_bank  = (addr[ADDR_W-1:OFF_W] == BANK_SEL);
        in_range = (32'(offset) < MEM_SIZE);
        in_id    = &offset[OFF_W-1:4];
    end
endmodule

// File: rtl/bridge_id_rom.sv
// bridge_id_rom: 16-entry identification byte table unpacked from a
// parameter vector; entry k sits in bits [8k+7:8k].
module bridge_id_rom #(
    parameter logic [127:0] ID_BYTES = 128'h4F4E4D4C4B4A49484746454443424140
) (
    input  logic [3:0] idx,
    output logic [7:0] id_byte
);
    localparam int unsigned N_ID = 16;

    logic [7:0] table_q [N_ID];

    // Unpack each slot of the parameter vector.
    for (genvar k = 0; k < N_ID; k++) begin : g_slot
        assign table_q[k] = ID_BYTES[8*k +: 8];
    end

    // Select the slot addressed by the low address bits.
    always_comb id_byte = table_q[idx];
endmodule

// File: rtl/bridge_req_gen.sv
// bridge_req_gen: turns start-of-cycle strobes into one-clock memory
// requests for in-bank, in-range accesses. Assumes the strobes are
// one-shot; a read takes priority if both arrive together.
module bridge_req_gen #(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned MEM_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic              in_bank,
    input  logic              in_range,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [MEM_AW-1:0] mem_addr
);
    logic hit;

    // Only accesses inside the implemented memory may reach it.
    always_comb hit = in_bank && in_range;

    // Register the request flags and latch the address on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_rd_req <= 1'b0;
            mem_wr_req <= 1'b0;
            mem_addr   <= '0;
        end else begin
            mem_rd_req <= rd_pulse && hit;
            mem_wr_req <= wr_pulse && hit && !rd_pulse;
            if ((rd_pulse || wr_pulse) && hit) begin
                mem_addr <= addr[MEM_AW-1:0];
            end
        end
    end

    // R3 R4: the two request kinds never overlap.
    assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req));
endmodule

// File: rtl/bridge_readback.sv
// bridge_readback: chooses the byte returned to the processor and drives
// the transceiver controls. Memory data waits for ready; gap reads are
// answered from the ID table or filler at once. Released on strobe fall.
module bridge_readback
    import bridge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_level,
    input  logic       in_bank,
    input  logic       in_range,
    input  logic       in_id,
    input  logic [7:0] id_byte,
    input  logic [7:0] mem_rdata,
    input  logic       mem_rdy,
    output logic [7:0] cpu_rdata,
    output logic       cpu_rdata_en,
    output logic       xcvr_dir_out,
    output logic       xcvr_oe_n
);
    localparam logic [7:0] FILL_BYTE = 8'hFF;

    rd_src_e    src;
    logic [7:0] src_byte;

    // Decide which source, if any, answers this cycle.
    always_comb begin
        src = SRC_NONE;
        if (rd_level && in_bank) begin
            if (!in_range)    src = in_id ? SRC_ID : SRC_FILL;
            else if (mem_rdy) src = SRC_MEM;
        end
    end

    // Pick the byte belonging to the chosen source.
    always_comb begin
        case (src)
            SRC_MEM:  src_byte = mem_rdata;
            SRC_ID:   src_byte = id_byte;
            default:  src_byte = FILL_BYTE;
        endcase
    end

    // Latch data and drive or release the transceiver controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rdata    <= '0;
            cpu_rdata_en <= 1'b0;
            xcvr_dir_out <= 1'b0;
            xcvr_oe_n    <= 1'b1;
        end else if (!rd_level) begin
            cpu_rdata_en <= 1'b0;
            xcvr_dir_out <= 1'b0;
            xcvr_oe_n    <= 1'b1;
        end else if (src != SRC_NONE) begin
            cpu_rdata    <= src_byte;
            cpu_rdata_en <= 1'b1;
            xcvr_dir_out <= 1'b1;
            xcvr_oe_n    <= 1'b0;
        end
    end

    // R8: driven data always comes with an enabled, outward transceiver.
    assert_drive_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata_en |-> (xcvr_dir_out && !xcvr_oe_n));

    // R9: a sampled low read strobe releases everything next cycle.
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_level |=> (!cpu_rdata_en && !xcvr_dir_out && xcvr_oe_n));

    // R2: data only starts being driven during an in-bank read.
    assert_drive_in_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rdata_en) |-> $past(rd_level && in_bank));
endmodule

// File: rtl/mem_window_bridge.sv
// mem_window_bridge: top of the processor-to-graphics-memory window
// bridge. Assumes a registered address and externally generated strobes;
// memory arbitration lies outside.
module mem_window_bridge #(
    parameter int unsigned ADDR_W   = 22,
    parameter int unsigned BANK_W   = 3,
    parameter int unsigned MEM_AW   = 20,
    parameter logic [BANK_W-1:0] BANK_SEL = 3'b010,
    parameter int unsigned MEM_SIZE = 32'h40000,
    parameter logic [127:0] ID_BYTES = 128'h4F4E4D4C4B4A49484746454443424140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_level,
    input  logic              wr_level,
    input  logic              rd_pulse,
    input  logic              wr_pulse,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_rdy,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rdata_en,
    output logic              xcvr_dir_out,
    output logic              xcvr_oe_n
);
    localparam int unsigned OFF_W = ADDR_W - BANK_W;

    logic       in_bank, in_range, in_id;
    logic [7:0] id_byte;

    bridge_window_decode #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .BANK_SEL(BANK_SEL), .MEM_SIZE(MEM_SIZE)
    ) i_decode (
        .addr(addr), .in_bank(in_bank), .in_range(in_range), .in_id(in_id)
    );

    bridge_id_rom #(.ID_BYTES(ID_BYTES)) i_id_rom (
        .idx(addr[3:0]), .id_byte(id_byte)
    );

    bridge_req_gen #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) i_req (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
        .in_bank(in_bank), .in_range(in_range),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr)
    );

    bridge_readback i_readback (
        .clk(clk), .rst_n(rst_n), .rd_level(rd_level),
        .in_bank(in_bank), .in_range(in_range), .in_id(in_id),
        .id_byte(id_byte), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
        .cpu_rdata(cpu_rdata), .cpu_rdata_en(cpu_rdata_en),
        .xcvr_dir_out(xcvr_dir_out), .xcvr_oe_n(xcvr_oe_n)
    );

    // R3: a read request follows a read strobe at an in-window, in-memory address.
    assert_rd_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> ($past(rd_pulse) && ($past(addr[ADDR_W-1:OFF_W]) == BANK_SEL)
                        && (32'($past(addr[OFF_W-1:0])) < MEM_SIZE)));

    // R4: a write request follows a write strobe below the memory size.
    assert_wr_req_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> ($past(wr_pulse) && ($past(addr[ADDR_W-1:OFF_W]) == BANK_SEL)
                        && (32'($past(addr[OFF_W-1:0])) < MEM_SIZE)));

    // R3: the request address is the low address bits seen with the strobe.
    assert_req_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req) |-> (mem_addr == $past(addr[MEM_AW-1:0])));

    // The level write strobe carries no decision here; it is observed only.
    assert_wr_level_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_level && !rd_level) |=> !cpu_rdata_en);
endmodule

// File: tb/test_mem_window_bridge.sv
module test_mem_window_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] addr = '0;
    logic        rd_level = 0, wr_level = 0, rd_pulse = 0, wr_pulse = 0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rdy = 0;
    logic        mem_rd_req, mem_wr_req, cpu_rdata_en, xcvr_dir_out, xcvr_oe_n;
    logic [19:0] mem_addr;
    logic [7:0]  cpu_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    mem_window_bridge i_mem_window_bridge (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_level(rd_level),
        .wr_level(wr_level), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse),
        .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .mem_rd_req(mem_rd_req),
        .mem_wr_req(mem_wr_req), .mem_addr(mem_addr), .cpu_rdata(cpu_rdata),
        .cpu_rdata_en(cpu_rdata_en), .xcvr_dir_out(xcvr_dir_out), .xcvr_oe_n(xcvr_oe_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        logic [21:0] a;
        logic        wr;
        logic        req;
        logic        drv;
        logic [7:0]  d;
    } vec_t;

    // address, write?, expect request, expect drive, expected byte
    localparam vec_t VECS [0:12] = '{
        '{22'h100123, 1'b0, 1'b1, 1'b1, 8'h79},  // R3 R5 in range
        '{22'h13FFFF, 1'b0, 1'b1, 1'b1, 8'hA5},  // R3 R5 last in range
        '{22'h140000, 1'b0, 1'b0, 1'b1, 8'hFF},  // R7 first above size
        '{22'h17FFF0, 1'b0, 1'b0, 1'b1, 8'h40},  // R6 slot 0
        '{22'h17FFF7, 1'b0, 1'b0, 1'b1, 8'h47},  // R6 slot 7
        '{22'h17FFFF, 1'b0, 1'b0, 1'b1, 8'h4F},  // R6 slot 15
        '{22'h17FFEF, 1'b0, 1'b0, 1'b1, 8'hFF},  // R7 just below ID slots
        '{22'h000123, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 other bank
        '{22'h300123, 1'b0, 1'b0, 1'b0, 8'h00},  // R2 other bank
        '{22'h100456, 1'b1, 1'b1, 1'b0, 8'h00},  // R4 in range write
        '{22'h140000, 1'b1, 1'b0, 1'b0, 8'h00},  // R4 write above size
        '{22'h17FFF3, 1'b1, 1'b0, 1'b0, 8'h00},  // R4 write into ID slots
        '{22'h200000, 1'b1, 1'b0, 1'b0, 8'h00}   // R2 write other bank
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_released(input string tag);
        chk(tag, {29'd0, cpu_rdata_en, xcvr_dir_out, xcvr_oe_n}, 32'b001);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        addr = v.a;
        mem_rdata = v.a[7:0] ^ 8'h5A;
        if (v.wr) begin wr_level = 1; wr_pulse = 1; end
        else      begin rd_level = 1; rd_pulse = 1; end
        @(negedge clk);
        rd_pulse = 0; wr_pulse = 0;
        chk(v.wr ? "R4 wr_req" : "R3 rd_req", {30'd0, mem_rd_req, mem_wr_req},
            v.req ? (v.wr ? 32'b01 : 32'b10) : 32'b00);
        if (v.req) chk("R3 mem_addr", 32'(mem_addr), 32'(v.a[19:0]));
        mem_rdy = 1;
        @(negedge clk);
        mem_rdy = 0;
        chk("R3 req one clock", {30'd0, mem_rd_req, mem_wr_req}, 32'b00);
        if (v.drv) begin
            chk("R8 drive", {29'd0, cpu_rdata_en, xcvr_dir_out, xcvr_oe_n}, 32'b110);
            chk(v.req ? "R5 data" : "R6/R7 data", 32'(cpu_rdata), 32'(v.d));
        end else begin
            chk_released("R2 no drive");
        end
        rd_level = 0; wr_level = 0;
        @(negedge clk);
        chk_released("R9 release");
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state while held in reset
        chk("R1 req", {30'd0, mem_rd_req, mem_wr_req}, 32'b00);
        chk_released("R1 controls");
        rst_n = 1;
        @(negedge clk);
        chk("R1 req after reset", {30'd0, mem_rd_req, mem_wr_req}, 32'b00);
        chk_released("R1 controls after reset");

        for (int i = 0; i < 13; i++) run_vec(VECS[i]);

        // R5: data waits for a delayed ready
        @(negedge clk);
        addr = 22'h100010; rd_level = 1; rd_pulse = 1; mem_rdata = 8'h3C;
        @(negedge clk);
        rd_pulse = 0;
        chk("R3 delayed rd_req", 32'(mem_rd_req), 32'd1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 wait for ready", 32'(cpu_rdata_en), 32'd0);
        end
        mem_rdy = 1;
        @(negedge clk);
        mem_rdy = 0;
        chk("R5 late data en", 32'(cpu_rdata_en), 32'd1);
        chk("R5 late data", 32'(cpu_rdata), 32'h3C);
        rd_level = 0;
        @(negedge clk);
        chk_released("R9 after late read");

        // R6: ID slot answered on the first edge, no request, no ready
        @(negedge clk);
        addr = 22'h17FFF3; rd_level = 1; rd_pulse = 1;
        @(negedge clk);
        rd_pulse = 0;
        chk("R6 immediate en", 32'(cpu_rdata_en), 32'd1);
        chk("R6 immediate data", 32'(cpu_rdata), 32'h43);
        chk("R6 no request", 32'(mem_rd_req), 32'd0);
        rd_level = 0;
        @(negedge clk);
        chk_released("R9 after ID read");

        // R1: reset during a driven read releases everything
        @(negedge clk);
        addr = 22'h17FFFF; rd_level = 1;
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        chk_released("R1 reset mid read");
        rst_n = 1; rd_level = 0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule